// File: doc/BRIEF.md
# BCD Event Counter with Timer and Alarm Flags

The block counts qualified events in a six-digit BCD counter. An event is a rising edge on `evt_i`, meaning the input is high in a cycle after being low in the cycle before. A two-digit BCD timer sits beside the counter. It is clocked from a counter decade that software picks, and it raises a timer flag when it rolls over. An alarm flag is raised in two cases: when the counter steps onto a programmed alarm value, or, if enabled, when the timer steps onto a programmed timer alarm value. Each flag has its own interrupt enable, and the interrupt request is the OR of the enabled flags.

Software drives the block over a simple write-only register bus (`we_i`, `addr_i`, `wdata_i`). Writes are captured on the clock edge and take effect from the next cycle. The counter value, the timer value, both flags and the interrupt are visible on the ports at all times.

Top module: `evt_alarm_ctl`

## Requirements
- R1: After reset the counter, the timer, both flags and the interrupt are zero, and the control register (address 0) is zero.
- R2: Each event advances the six-digit BCD counter by one, carrying between decades and wrapping from 999999 to 000000. A level held high counts only once, and with no event the counter holds.
- R3: With control bits [2:0] = 111 (test code), every event adds one to each counter digit and each timer digit on its own, with no carry (9 goes to 0). This wrap does not set the timer flag.
- R4: Control bits [2:0] pick the timer tick. 001 ticks on every event. 010 ticks when a carry enters the hundreds digit. 011 ticks when a carry enters the ten-thousands digit. 100 ticks when the counter wraps out of its top digit. Codes 000, 101 and 110 leave the timer unchanged.
- R5: The timer flag sets when a tick takes the two-digit timer from 99 to 00.
- R6: When control bits [5:4] = 01, the alarm flag sets when an event takes the counter to a value equal to the alarm value. Codes 00, 10 and 11 never set it. The alarm value is written as BCD bytes: address 1 holds digits 1:0, address 2 holds digits 3:2, address 3 holds digits 5:4.
- R7: When control bit 6 is 1, the alarm flag sets when a timer tick takes the timer to the value held at address 4.
- R8: Both flags stay set until cleared. Writing address 5 with bit 0 set clears the timer flag, and with bit 1 set clears the alarm flag. If a flag is set in the same cycle as its clear, the set wins.
- R9: `irq_o` is high when the timer flag is set with control bit 3 = 1, or when the alarm flag is set with control bit 7 = 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| evt_i | input | 1 | Event input, counted on its rising edge |
| we_i | input | 1 | Register write strobe |
| addr_i | input | 3 | Register address |
| wdata_i | input | 8 | Register write data |
| count_o | output | 24 | Counter value, six BCD digits |
| timer_o | output | 8 | Timer value, two BCD digits |
| tflag_o | output | 1 | Timer flag |
| aflag_o | output | 1 | Alarm flag |
| irq_o | output | 1 | Interrupt request |

## Verification
The case that needs care is a flag being set in the same cycle as a write that clears it. The bench provokes this on purpose for the timer flag. It counts 99 events in units mode, then drives the hundredth event in the same cycle as a clear write to address 5. The timer flag must still be high in the next cycle. The random phase mixes clear writes with events and alarm-value writes, so the same clash also comes up at random for both flags. A cycle-level model in the bench judges each outcome.

// File: rtl/evt_pkg.sv
package evt_pkg;

   typedef enum logic [2:0] {
      TM_OFF   = 3'd0,
      TM_UNITS = 3'd1,
      TM_HUND  = 3'd2,
      TM_TENK  = 3'd3,
      TM_MILL  = 3'd4,
      TM_RSV5  = 3'd5,
      TM_RSV6  = 3'd6,
      TM_PAR   = 3'd7
   } tsel_e;

   typedef struct packed {
      logic       aie;
      logic       tae;
      logic [1:0] afn;
      logic       tie;
      tsel_e      tsel;
   } ctl_t;

   localparam logic [1:0] AFN_EVENT = 2'b01;

   localparam int unsigned TIMER_DIGITS = 2;

endpackage

// File: rtl/evt_bcd_chain.sv
module evt_bcd_chain #(
   parameter int unsigned DIGITS = 6
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  inc,
   input  logic                  par,
   output logic [DIGITS*4-1:0]   q_o,
   output logic [DIGITS*4-1:0]   nxt_o,
   output logic [DIGITS:0]       carry_o
);

   logic [DIGITS-1:0] nines;

   assign carry_o[0] = inc;

   generate
      if (DIGITS < 1) begin : g_bad_digits
         $error("evt_bcd_chain: DIGITS must be at least 1");
      end
      for (genvar i = 0; i < DIGITS; i++) begin : g_digit
         logic [3:0] d;
         logic       step;
         assign d        = q_o[i*4 +: 4];
         assign nines[i] = (d == 4'd9);
         assign step     = par ? inc : carry_o[i];
         assign carry_o[i+1] = inc & ~par & (&nines[i:0]);
         assign nxt_o[i*4 +: 4] = step ? (nines[i] ? 4'd0 : d + 4'd1) : d;

         assert_digit_bcd_R2 : assert property (@(posedge clk) disable iff (!rst_n)
            q_o[i*4 +: 4] <= 4'd9);
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) q_o <= '0;
      else        q_o <= nxt_o;
   end

endmodule

// File: rtl/evt_regs.sv
module evt_regs
   import evt_pkg::*;
#(
   parameter int unsigned DIGITS = 6,
   parameter int unsigned AW     = 3
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  we,
   input  logic [AW-1:0]         addr,
   input  logic [7:0]            wdata,
   output ctl_t                  ctl_o,
   output logic [DIGITS*4-1:0]   alm_o,
   output logic [7:0]            talm_o,
   output logic                  clr_tf_o,
   output logic                  clr_af_o
);

   localparam int unsigned ABYTES = DIGITS / 2;
   localparam int unsigned A_TALM = ABYTES + 1;
   localparam int unsigned A_CLR  = ABYTES + 2;

   generate
      if ((1 << AW) < A_CLR + 1) begin : g_bad_aw
         $error("evt_regs: AW too small for register map");
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ctl_o  <= '0;
         talm_o <= '0;
      end else if (we) begin
         if (addr == AW'(0))      ctl_o  <= ctl_t'(wdata);
         if (addr == AW'(A_TALM)) talm_o <= wdata;
      end
   end

   generate
      for (genvar b = 0; b < ABYTES; b++) begin : g_alm
         always_ff @(posedge clk) begin
            if (!rst_n)                        alm_o[b*8 +: 8] <= '0;
            else if (we && addr == AW'(b + 1)) alm_o[b*8 +: 8] <= wdata;
         end
      end
   endgenerate

   assign clr_tf_o = we && (addr == AW'(A_CLR)) && wdata[0];
   assign clr_af_o = we && (addr == AW'(A_CLR)) && wdata[1];

endmodule

// File: rtl/evt_flags.sv
module evt_flags (
   input  logic clk,
   input  logic rst_n,
   input  logic set_tf,
   input  logic set_af,
   input  logic clr_tf,
   input  logic clr_af,
   input  logic tie,
   input  logic aie,
   output logic tf_o,
   output logic af_o,
   output logic irq_o
);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         tf_o <= 1'b0;
         af_o <= 1'b0;
      end else begin
         tf_o <= set_tf | (tf_o & ~clr_tf);
         af_o <= set_af | (af_o & ~clr_af);
      end
   end

   assign irq_o = (tf_o & tie) | (af_o & aie);

   assert_tset_wins_R8 : assert property (@(posedge clk) disable iff (!rst_n)
      set_tf |=> tf_o);
   assert_aset_wins_R8 : assert property (@(posedge clk) disable iff (!rst_n)
      set_af |=> af_o);
   assert_tsticky_R8 : assert property (@(posedge clk) disable iff (!rst_n)
      (tf_o && !clr_tf) |=> tf_o);
   assert_asticky_R8 : assert property (@(posedge clk) disable iff (!rst_n)
      (af_o && !clr_af) |=> af_o);

endmodule

// File: rtl/evt_alarm_ctl.sv
module evt_alarm_ctl
   import evt_pkg::*;
#(
   parameter int unsigned DIGITS = 6,
   parameter int unsigned AW     = 3
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  evt_i,
   input  logic                  we_i,
   input  logic [AW-1:0]         addr_i,
   input  logic [7:0]            wdata_i,
   output logic [DIGITS*4-1:0]   count_o,
   output logic [TIMER_DIGITS*4-1:0] timer_o,
   output logic                  tflag_o,
   output logic                  aflag_o,
   output logic                  irq_o
);

   localparam int unsigned IX_UNITS = 0;
   localparam int unsigned IX_HUND  = 2;
   localparam int unsigned IX_TENK  = 4;
   localparam int unsigned IX_MILL  = 6;
   localparam int unsigned IXW      = $clog2(DIGITS + 1);

   generate
      if (DIGITS < 6 || (DIGITS % 2) != 0) begin : g_bad_digits
         $error("evt_alarm_ctl: DIGITS must be even and at least 6");
      end
   endgenerate

   ctl_t                      ctl;
   logic [DIGITS*4-1:0]       alm;
   logic [7:0]                talm;
   logic                      clr_tf, clr_af;
   logic                      evt_q, evt_edge, par;
   logic [DIGITS*4-1:0]       cnt_nxt;
   logic [DIGITS:0]           cnt_carry;
   logic [TIMER_DIGITS*4-1:0] tmr_nxt;
   logic [TIMER_DIGITS:0]     tmr_carry;
   logic [IXW-1:0]            tap_ix;
   logic                      tap_en, tick, set_tf, set_af;

   always_ff @(posedge clk) begin
      if (!rst_n) evt_q <= 1'b0;
      else        evt_q <= evt_i;
   end

   assign evt_edge = evt_i & ~evt_q;
   assign par      = (ctl.tsel == TM_PAR);

   evt_regs #(.DIGITS(DIGITS), .AW(AW)) u_regs (
      .clk      (clk),
      .rst_n    (rst_n),
      .we       (we_i),
      .addr     (addr_i),
      .wdata    (wdata_i),
      .ctl_o    (ctl),
      .alm_o    (alm),
      .talm_o   (talm),
      .clr_tf_o (clr_tf),
      .clr_af_o (clr_af)
   );

   evt_bcd_chain #(.DIGITS(DIGITS)) u_cnt (
      .clk     (clk),
      .rst_n   (rst_n),
      .inc     (evt_edge),
      .par     (par),
      .q_o     (count_o),
      .nxt_o   (cnt_nxt),
      .carry_o (cnt_carry)
   );

   always_comb begin
      tap_en = 1'b1;
      tap_ix = IXW'(IX_UNITS);
      case (ctl.tsel)
         TM_UNITS: tap_ix = IXW'(IX_UNITS);
         TM_HUND:  tap_ix = IXW'(IX_HUND);
         TM_TENK:  tap_ix = IXW'(IX_TENK);
         TM_MILL:  tap_ix = IXW'(IX_MILL);
         TM_PAR:   tap_ix = IXW'(IX_UNITS);
         default:  tap_en = 1'b0;
      endcase
   end

   assign tick = tap_en & cnt_carry[tap_ix];

   evt_bcd_chain #(.DIGITS(TIMER_DIGITS)) u_tmr (
      .clk     (clk),
      .rst_n   (rst_n),
      .inc     (tick),
      .par     (par),
      .q_o     (timer_o),
      .nxt_o   (tmr_nxt),
      .carry_o (tmr_carry)
   );

   assign set_tf = tmr_carry[TIMER_DIGITS];
   assign set_af = (evt_edge && ctl.afn == AFN_EVENT && cnt_nxt == alm) ||
                   (tick && ctl.tae && tmr_nxt == talm);

   evt_flags u_flags (
      .clk    (clk),
      .rst_n  (rst_n),
      .set_tf (set_tf),
      .set_af (set_af),
      .clr_tf (clr_tf),
      .clr_af (clr_af),
      .tie    (ctl.tie),
      .aie    (ctl.aie),
      .tf_o   (tflag_o),
      .af_o   (aflag_o),
      .irq_o  (irq_o)
   );

   assert_count_hold_R2 : assert property (@(posedge clk) disable iff (!rst_n)
      !(evt_i && !evt_q) |=> $stable(count_o));
   assert_timer_hold_R4 : assert property (@(posedge clk) disable iff (!rst_n)
      (ctl.tsel == TM_OFF || ctl.tsel == TM_RSV5 || ctl.tsel == TM_RSV6) |=> $stable(timer_o));
   assert_alarm_off_R6 : assert property (@(posedge clk) disable iff (!rst_n)
      (ctl.afn != AFN_EVENT && !ctl.tae) |=> !$rose(aflag_o));
   assert_test_no_tflag_R3 : assert property (@(posedge clk) disable iff (!rst_n)
      (ctl.tsel == TM_PAR) |=> !$rose(tflag_o));

endmodule

// File: tb/evt_alarm_ctl_bench.sv
`timescale 1ns/1ps
module evt_alarm_ctl_bench;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        evt_i = 1'b0;
   logic        we_i = 1'b0;
   logic [2:0]  addr_i = '0;
   logic [7:0]  wdata_i = '0;
   logic [23:0] count_o;
   logic [7:0]  timer_o;
   logic        tflag_o, aflag_o, irq_o;

   int total = 0;
   int bad   = 0;

   logic [23:0] m_cnt, m_alm;
   logic [7:0]  m_tmr, m_ctl, m_talm;
   logic        m_tf, m_af, m_evq;

   always #2 clk = ~clk;

   evt_alarm_ctl u_evt_alarm_ctl (
      .clk (clk), .rst_n (rst_n), .evt_i (evt_i), .we_i (we_i),
      .addr_i (addr_i), .wdata_i (wdata_i), .count_o (count_o),
      .timer_o (timer_o), .tflag_o (tflag_o), .aflag_o (aflag_o), .irq_o (irq_o)
   );

   function automatic logic [23:0] inc_bcd(input logic [23:0] v, input int nd, input bit par);
      logic [23:0] r;
      bit          c;
      r = v;
      c = 1'b1;
      for (int i = 0; i < nd; i++) begin
         logic [3:0] d;
         d = v[i*4 +: 4];
         if (par) r[i*4 +: 4] = (d == 4'd9) ? 4'd0 : d + 4'd1;
         else if (c) begin
            if (d == 4'd9) r[i*4 +: 4] = 4'd0;
            else begin r[i*4 +: 4] = d + 4'd1; c = 1'b0; end
         end
      end
      return r;
   endfunction

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic model_reset();
      m_cnt = '0; m_alm = '0; m_tmr = '0; m_ctl = '0; m_talm = '0;
      m_tf = 1'b0; m_af = 1'b0; m_evq = 1'b0;
   endtask

   task automatic check_all();
      chk("R2 counter", 32'(count_o), 32'(m_cnt));
      chk("R4 timer", 32'(timer_o), 32'(m_tmr));
      chk("R5 tflag", 32'(tflag_o), 32'(m_tf));
      chk("R6/R7 aflag", 32'(aflag_o), 32'(m_af));
      chk("R9 irq", 32'(irq_o), 32'((m_tf & m_ctl[3]) | (m_af & m_ctl[7])));
   endtask

   task automatic drive(input logic e, input logic w, input logic [2:0] a, input logic [7:0] d);
      logic        edg, par, tick, stf, saf, ctf, caf;
      logic [23:0] cn, tn;
      evt_i = e; we_i = w; addr_i = a; wdata_i = d;
      edg  = e & ~m_evq;
      par  = (m_ctl[2:0] == 3'd7);
      cn   = edg ? inc_bcd(m_cnt, 6, par) : m_cnt;
      case (m_ctl[2:0])
         3'd1, 3'd7: tick = edg;
         3'd2:       tick = edg && (m_cnt[7:0] == 8'h99);
         3'd3:       tick = edg && (m_cnt[15:0] == 16'h9999);
         3'd4:       tick = edg && (m_cnt == 24'h999999);
         default:    tick = 1'b0;
      endcase
      tn  = tick ? inc_bcd({16'h0, m_tmr}, 2, par) : {16'h0, m_tmr};
      stf = tick && !par && (m_tmr == 8'h99);
      saf = (edg && m_ctl[5:4] == 2'b01 && cn == m_alm) ||
            (tick && m_ctl[6] && tn[7:0] == m_talm);
      ctf = w && a == 3'd5 && d[0];
      caf = w && a == 3'd5 && d[1];
      @(posedge clk);
      m_tf  = stf | (m_tf & ~ctf);
      m_af  = saf | (m_af & ~caf);
      m_cnt = cn;
      m_tmr = tn[7:0];
      m_evq = e;
      if (w) begin
         case (a)
            3'd0: m_ctl = d;
            3'd1: m_alm[7:0] = d;
            3'd2: m_alm[15:8] = d;
            3'd3: m_alm[23:16] = d;
            3'd4: m_talm = d;
            default: ;
         endcase
      end
      @(negedge clk);
      check_all();
   endtask

   task automatic wr(input logic [2:0] a, input logic [7:0] d);
      drive(1'b0, 1'b1, a, d);
   endtask

   task automatic events(input int n);
      for (int i = 0; i < n; i++) begin
         drive(1'b1, 1'b0, 3'd0, 8'h0);
         drive(1'b0, 1'b0, 3'd0, 8'h0);
      end
   endtask

   task automatic do_reset();
      rst_n = 1'b0; evt_i = 1'b0; we_i = 1'b0;
      model_reset();
      repeat (3) @(posedge clk);
      @(negedge clk);
      chk("R1 reset counter", 32'(count_o), 32'h0);
      chk("R1 reset timer", 32'(timer_o), 32'h0);
      chk("R1 reset flags", 32'({tflag_o, aflag_o, irq_o}), 32'h0);
      rst_n = 1'b1;
   endtask

   initial begin
      #(4 * 150000);
      bad++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      logic [23:0] tgt;
      void'($urandom(32'h1A2B3C));
      do_reset();

      // R2: counting and held level
      events(5);
      drive(1'b1, 1'b0, 3'd0, 8'h0);
      drive(1'b1, 1'b0, 3'd0, 8'h0);
      drive(1'b1, 1'b0, 3'd0, 8'h0);
      drive(1'b0, 1'b0, 3'd0, 8'h0);
      chk("R2 held level counts once", 32'(count_o), 32'h6);

      // R4 units, R5 rollover
      wr(3'd0, 8'h01);
      events(3);
      chk("R4 units tick", 32'(timer_o), 32'h03);
      events(97);
      chk("R5 timer rollover flag", 32'(tflag_o), 32'h1);
      chk("R2 carry into hundreds", 32'(count_o), 32'h000106);
      chk("R9 irq masked", 32'(irq_o), 32'h0);
      wr(3'd0, 8'h09);
      chk("R9 irq timer enabled", 32'(irq_o), 32'h1);

      // R8 clear, then clear colliding with set
      wr(3'd5, 8'h01);
      chk("R8 clear timer flag", 32'(tflag_o), 32'h0);
      events(99);
      drive(1'b1, 1'b1, 3'd5, 8'h01);
      chk("R8 set beats clear", 32'(tflag_o), 32'h1);
      drive(1'b0, 1'b0, 3'd0, 8'h0);

      // R6 negative with reserved code, then positive
      tgt = inc_bcd(m_cnt, 6, 1'b0);
      wr(3'd1, tgt[7:0]); wr(3'd2, tgt[15:8]); wr(3'd3, tgt[23:16]);
      wr(3'd0, 8'h20);
      events(1);
      chk("R6 reserved alarm code ignored", 32'(aflag_o), 32'h0);
      tgt = inc_bcd(inc_bcd(inc_bcd(m_cnt, 6, 1'b0), 6, 1'b0), 6, 1'b0);
      wr(3'd1, tgt[7:0]); wr(3'd2, tgt[15:8]); wr(3'd3, tgt[23:16]);
      wr(3'd0, 8'h90);
      events(2);
      chk("R6 no alarm before match", 32'(aflag_o), 32'h0);
      events(1);
      chk("R6 event alarm", 32'(aflag_o), 32'h1);
      chk("R9 irq alarm enabled", 32'(irq_o), 32'h1);

      // R7 timer alarm
      wr(3'd5, 8'h03);
      chk("R8 clear both flags", 32'({tflag_o, aflag_o}), 32'h0);
      wr(3'd0, 8'h41);
      tgt = inc_bcd(inc_bcd({16'h0, m_tmr}, 2, 1'b0), 2, 1'b0);
      wr(3'd4, tgt[7:0]);
      events(1);
      chk("R7 no alarm before timer match", 32'(aflag_o), 32'h0);
      events(1);
      chk("R7 timer alarm", 32'(aflag_o), 32'h1);

      // R4 reserved code holds timer; hundreds tap
      tgt = {16'h0, m_tmr};
      wr(3'd0, 8'h05);
      events(4);
      chk("R4 reserved code holds timer", 32'(timer_o), 32'(tgt));
      wr(3'd0, 8'h02);
      events(120);

      // R3 test mode from reset, then wrap through millions tap
      do_reset();
      wr(3'd0, 8'h07);
      events(1);
      chk("R3 parallel step", 32'(count_o), 32'h111111);
      events(8);
      chk("R3 parallel to all nines", 32'(count_o), 32'h999999);
      chk("R3 timer parallel", 32'(timer_o), 32'h99);
      chk("R3 no tflag in test mode", 32'(tflag_o), 32'h0);
      wr(3'd0, 8'h04);
      events(1);
      chk("R2 wrap to zero", 32'(count_o), 32'h0);
      chk("R4 millions tick", 32'(timer_o), 32'h00);
      chk("R5 tflag on millions wrap", 32'(tflag_o), 32'h1);

      // random phase
      for (int n = 0; n < 6000; n++) begin
         logic       e, w;
         logic [2:0] a;
         logic [7:0] d;
         e = 1'($urandom % 2);
         w = (($urandom % 12) == 0);
         a = 3'($urandom % 6);
         d = 8'($urandom);
         if (a == 3'd0) d[2:0] = ($urandom % 3 == 0) ? 3'd1 : d[2:0];
         if (a == 3'd1) d = inc_bcd(inc_bcd(m_cnt, 6, 1'b0), 6, 1'b0) >> 0;
         if (a == 3'd4) d = inc_bcd({16'h0, m_tmr}, 2, 1'b0) >> 0;
         drive(e, w, a, d);
      end

      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule